// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block moves 8-bit channels between slots of a time-division multiplexed frame. Every clock cycle carries one channel. An internal slot counter gives that channel's linear index, stream-major: `index = stream * CHANNELS + channel`. The counter exposes the index so the upstream serial logic can align its data to it. The incoming byte of every slot is stored in a two-bank data memory. The banks swap roles at each frame boundary: one frame is written while the frame before it is read.

For every output slot, a connection memory entry says what to send. A normal entry names a source slot of the previous frame. A message entry supplies a fixed byte. Any entry can also flag its output slot as high impedance. Software loads the entries through a simple write port into a staging copy. The staging copy is transferred to the working copy in one step at the frame boundary, so a frame never mixes old and new connections.

Because every source is read one frame after it was written, the delay from input slot `i` to output slot `o` is fixed. It does not depend on the order in which the channels arrive.

Top module: `tdm_tsi_switch`

## Requirements
- R1: After reset the slot counter is 0 and all outputs are 0. Until the switched data of the first full frame appears, `outData` and `outHiZ` stay 0.
- R2: With entry bit 0 = 0, output slot `o` of frame `f` carries the input byte of slot `s` in frame `f-1`, where `s` is entry bits `[2 +: SLOT_W]`. The byte appears on `outData` one cycle after slot `o` is shown on `curSlot`, giving a fixed `NUM_SLOTS + o - s + 1` cycle delay.
- R3: With entry bit 0 = 1, output slot `o` carries entry bits `[9:2]` instead of switched data.
- R4: Entry bit 1 = 1 drives `outHiZ` high for that output slot, in either mode, in the same cycle as its data.
- R5: A connection write made during frame `f` first affects output of frame `f+1`, including a write in the last slot of frame `f`. Frame `f` itself uses the entries in force at its start.
- R6: `curSlot` counts 0 to `NUM_SLOTS-1` and wraps. `outFrame` is high exactly with the output of slot 0, once every `NUM_SLOTS` cycles.
- R7: When one entry is written several times within a frame, the last write is the one that takes effect.
- R8: Several output slots may name the same source slot, and each of them then carries that source byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one channel slot per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| inData | input | 8 | Input byte of the slot shown on `curSlot` |
| curSlot | output | SLOT_W | Linear index of the current slot |
| cfgWrEn | input | 1 | Connection entry write strobe |
| cfgAddr | input | SLOT_W | Output slot whose entry is written |
| cfgWrData | input | CM_W | Entry: bit 0 mode, bit 1 high-Z, bits 2 and up source or byte |
| outData | output | 8 | Switched or message byte, one cycle after its slot |
| outHiZ | output | 1 | High-impedance flag aligned with `outData` |
| outFrame | output | 1 | Marks the output of slot 0 |

## Verification
The bench builds the block with 2 streams of 8 channels. This gives a 16-slot frame, so ten frames fit in a few hundred cycles. The short frame lets a single run reach every frame-boundary case: writes in the last slot of a frame, repeated writes to one entry, one source broadcast to many outputs, and message and high-impedance entries mixed with normal switching. The source field is 4 bits wide, so every slot can be named as a source and compared cycle by cycle.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  // connection entry field positions (decoded by the datapath)
  localparam int MODE_BIT  = 0;
  localparam int HIZ_BIT   = 1;
  localparam int FIELD_LSB = 2;

  typedef struct packed {
    logic frameEnd;  // last slot of the frame
    logic wrBank;    // data bank written this frame
  } tsiStrobe_t;
endpackage

// File: rtl/tsi_ctrl.sv
module tsi_ctrl
  import tsi_pkg::*;
#(
  parameter int NUM_SLOTS = 512,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [SLOT_W-1:0] slot,
  output tsiStrobe_t        strobe
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);

  logic bank;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slot <= '0;
      bank <= 1'b0;
    end else if (slot == LAST) begin
      slot <= '0;
      bank <= ~bank;
    end else begin
      slot <= slot + 1'b1;
    end
  end

  always_comb begin
    strobe.frameEnd = (slot == LAST);
    strobe.wrBank   = bank;
  end
endmodule

// File: rtl/tsi_datapath.sv
module tsi_datapath
  import tsi_pkg::*;
#(
  parameter int NUM_SLOTS = 512,
  parameter int DATA_W    = 8,
  parameter int CM_W      = 12,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  tsiStrobe_t        strobe,
  input  logic [SLOT_W-1:0] slot,
  input  logic [DATA_W-1:0] inData,
  input  logic              cfgWrEn,
  input  logic [SLOT_W-1:0] cfgAddr,
  input  logic [CM_W-1:0]   cfgWrData,
  output logic [DATA_W-1:0] outData,
  output logic              outHiZ,
  output logic              outFrame
);
  logic [DATA_W-1:0] dataMem [2][NUM_SLOTS];
  logic [CM_W-1:0]   stageCm [NUM_SLOTS];
  logic [CM_W-1:0]   workCm  [NUM_SLOTS];

  logic              rdBank;
  logic [CM_W-1:0]   entry;
  logic [SLOT_W-1:0] srcSlot;
  logic [DATA_W-1:0] msgByte;

  // two banks: write current frame, read previous frame
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < NUM_SLOTS; i++)
          dataMem[b][i] <= '0;
    end else begin
      dataMem[strobe.wrBank][slot] <= inData;
    end
  end

  // staging copy takes writes; working copy loads at frame end,
  // folding in a write made in that same cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        stageCm[i] <= '0;
        workCm[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (cfgWrEn && cfgAddr == SLOT_W'(i))
          stageCm[i] <= cfgWrData;
        if (strobe.frameEnd)
          workCm[i] <= (cfgWrEn && cfgAddr == SLOT_W'(i)) ? cfgWrData : stageCm[i];
      end
    end
  end

  always_comb begin
    rdBank  = ~strobe.wrBank;
    entry   = workCm[slot];
    srcSlot = entry[FIELD_LSB +: SLOT_W];
    msgByte = entry[FIELD_LSB +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outData  <= '0;
      outHiZ   <= 1'b0;
      outFrame <= 1'b0;
    end else begin
      outData  <= entry[MODE_BIT] ? msgByte : dataMem[rdBank][srcSlot];
      outHiZ   <= entry[HIZ_BIT];
      outFrame <= (slot == '0);
    end
  end
endmodule

// File: rtl/tdm_tsi_switch.sv
module tdm_tsi_switch
  import tsi_pkg::*;
#(
  parameter int STREAMS  = 16,
  parameter int CHANNELS = 32,
  parameter int DATA_W   = 8,
  parameter int CM_W     = 12,
  localparam int NUM_SLOTS = STREAMS * CHANNELS,
  localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  output logic [SLOT_W-1:0] curSlot,
  input  logic              cfgWrEn,
  input  logic [SLOT_W-1:0] cfgAddr,
  input  logic [CM_W-1:0]   cfgWrData,
  output logic [DATA_W-1:0] outData,
  output logic              outHiZ,
  output logic              outFrame
);
  tsiStrobe_t strobe;

  tsi_ctrl #(.NUM_SLOTS(NUM_SLOTS)) i_ctrl (
    .clk(clk), .rstN(rstN), .slot(curSlot), .strobe(strobe)
  );

  tsi_datapath #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W), .CM_W(CM_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .slot(curSlot),
    .inData(inData), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .outData(outData), .outHiZ(outHiZ),
    .outFrame(outFrame)
  );
endmodule

// File: rtl/tsi_checker.sv
module tsi_checker #(
  parameter int NUM_SLOTS = 512,
  parameter int DATA_W    = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] outData,
  input logic              outHiZ,
  input logic              outFrame
);
  int  periodCnt;
  int  frameCnt;
  logic seenFrame;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodCnt <= 0;
      frameCnt  <= 0;
      seenFrame <= 1'b0;
    end else begin
      if (outFrame) begin
        periodCnt <= 1;
        seenFrame <= 1'b1;
        if (frameCnt < 2) frameCnt <= frameCnt + 1;
      end else if (periodCnt <= NUM_SLOTS) begin
        periodCnt <= periodCnt + 1;
      end
    end
  end

  // R6
  frame_on_period_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outFrame && seenFrame) |-> (periodCnt == NUM_SLOTS));

  // R6
  frame_not_late_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seenFrame && periodCnt == NUM_SLOTS) |-> outFrame);

  // R1
  quiet_first_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameCnt == 0 || (frameCnt == 1 && !outFrame)) |-> (outData == '0 && !outHiZ));

  // R2
  known_output_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$isunknown({outData, outHiZ, outFrame}));
endmodule

bind tdm_tsi_switch tsi_checker #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)) i_chk (
  .clk(clk), .rstN(rstN), .outData(outData), .outHiZ(outHiZ), .outFrame(outFrame)
);

// File: tb/test_tdm_tsi_switch.sv
module test_tdm_tsi_switch;
  localparam int STREAMS  = 2;
  localparam int CHANNELS = 8;
  localparam int N        = STREAMS * CHANNELS;
  localparam int SW       = $clog2(N);
  localparam int FRAMES   = 10;
  localparam int TOTAL    = FRAMES * N;

  logic          clk = 1'b0;
  logic          rstN;
  logic [7:0]    inData;
  logic [SW-1:0] curSlot;
  logic          cfgWrEn;
  logic [SW-1:0] cfgAddr;
  logic [11:0]   cfgWrData;
  logic [7:0]    outData;
  logic          outHiZ;
  logic          outFrame;

  always #2.5 clk = ~clk;

  tdm_tsi_switch #(.STREAMS(STREAMS), .CHANNELS(CHANNELS)) i_tdm_tsi_switch (
    .clk(clk), .rstN(rstN), .inData(inData), .curSlot(curSlot),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .outData(outData), .outHiZ(outHiZ), .outFrame(outFrame)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int inHist [TOTAL];
  int stageM [N];
  int workM  [N];

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // connection write schedule
  task automatic sched(input int k, output bit en, output int a, output int d);
    en = 0; a = 0; d = 0;
    if (k >= 2*N && k < 3*N) begin          // reverse permutation
      en = 1; a = k - 2*N; d = (N - 1 - a) << 2;
    end else if (k >= 4*N && k < 5*N) begin // mixed modes
      en = 1; a = k - 4*N;
      case (a % 4)
        0: d = ((8'hA0 + a) << 2) | 1;
        1: d = (3 << 2) | 2;
        2: d = (5 << 2);
        default: d = ((8'h30 + a) << 2) | 3;
      endcase
    end else if (k >= 6*N && k < 6*N + 8) begin // repeated writes, last wins
      en = 1; a = 7; d = (k - 6*N + 2) << 2;
    end else if (k == 7*N - 1) begin        // write in last slot
      en = 1; a = 0; d = (8'h5C << 2) | 1;
    end
  endtask

  initial begin
    int expD, expZ, expF, f, s, ent;
    string tag;
    bit en; int a, d;
    rstN = 0; inData = 0; cfgWrEn = 0; cfgAddr = 0; cfgWrData = 0;
    for (int i = 0; i < N; i++) begin stageM[i] = 0; workM[i] = 0; end
    repeat (3) @(negedge clk);
    check("R1", outData, 0);
    check("R1", outHiZ, 0);
    check("R1", outFrame, 0);
    check("R1", curSlot, 0);
    rstN = 1;
    for (int k = 0; k < TOTAL; k++) begin
      check("R6", curSlot, k % N);
      inHist[k] = (k * 37 + 11) & 255;
      inData = 8'(inHist[k]);
      sched(k, en, a, d);
      cfgWrEn = en; cfgAddr = SW'(a); cfgWrData = 12'(d);
      @(posedge clk);
      f = k / N; s = k % N; ent = workM[s];
      expF = (s == 0);
      if (f == 0) begin
        expD = 0; expZ = 0;
      end else begin
        expZ = (ent >> 1) & 1;
        if (ent & 1) expD = (ent >> 2) & 255;
        else expD = inHist[(f - 1) * N + ((ent >> 2) & (N - 1))];
      end
      if (f == 0) tag = "R1";
      else if (f == 2 || (f == 7 && s == 0)) tag = "R5";
      else if (f == 7 && s == 7) tag = "R7";
      else if (ent & 1) tag = "R3";
      else if (f == 5 && s % 4 == 2) tag = "R8";
      else tag = "R2";
      if (en) stageM[a] = d;
      if (s == N - 1) for (int i = 0; i < N; i++) workM[i] = stageM[i];
      @(negedge clk);
      check(tag, outData, expD);
      check("R4", outHiZ, expZ);
      check("R6", outFrame, expF);
    end
    cfgWrEn = 0;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule